// File: doc/BRIEF.md
# Octal PSRAM mode-register configuration and identification sequencer

This block brings an octal PSRAM into a known operating state after power-up and reports what kind of device is attached. On a start pulse it asks a transaction engine to read mode register 0. It then replaces only three fields of that register: the latency type, the read-latency code and the drive-strength code. The merged byte is written back to the same address.

After the write it reads mode registers 0, 2, 4 and 8 in turn. It keeps the bytes it needs and decodes them into device parameters: density in Mbit, read latency in clock cycles, burst length in bytes and a good-die flag. A done output tells the rest of the system when these outputs can be used.

The block talks to the transaction engine through a request port and a response port. A request is held until the engine accepts it. The block then waits for exactly one response before it issues the next request. The bus protocol and any clock-speed switching belong to the engine, not to this block.

Top module: `psram_cfg_seq`

## Requirements
- R1: After an accepted start, the requests are issued in this order: read of address 0, write to address 0, then reads of addresses 0x0, 0x2, 0x4 and 0x8. Each request keeps req_valid_o, its address and its direction stable until req_ready_i is seen. The next request waits for one rsp_valid_i pulse, and writes are answered with a response just as reads are.
- R2: The write data keeps bits [7:6] from the byte returned by the configuration read. Bit 5 (latency type, 1 = fixed) is set to 1. Bits [4:2] (read-latency code) are set to 2. Bits [1:0] (drive-strength code) are set to 0.
- R3: The configuration read and the configuration write both use register address 0.
- R4: size_mbit_o decodes bits [2:0] of the MR2 read as follows: 1 gives 32, 3 gives 64, 5 gives 128 and 7 gives 256. Any other code gives 0.
- R5: good_die_o equals bit 7 of the MR2 read (1 = pass).
- R6: rd_lat_o equals (bits [4:2] of the identification read of MR0) × 2 + 6.
- R7: burst_bytes_o decodes bits [1:0] of the MR8 read as follows: 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 1024. Bit 2, the hybrid-wrap bit, does not change the value.
- R8: done_o rises only after the response to the MR8 read. It stays high, with no request issued, until the next start is accepted, and it falls in the cycle after that start.
- R9: A start pulse while a sequence is running is ignored. No extra requests are issued.
- R10: A response pulse while no request is outstanding changes no output.
- R11: After reset, done_o is 0, req_valid_o is 0, size_mbit_o is 0, rd_lat_o is 6, burst_bytes_o is 16 and good_die_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts the sequence when idle or done |
| done_o | output | 1 | Sequence complete, decoded outputs valid |
| req_valid_o | output | 1 | Request to the transaction engine |
| req_ready_i | input | 1 | Engine accepts the request |
| req_write_o | output | 1 | 1 = register write, 0 = register read |
| req_addr_o | output | ADDR_W | Mode register address |
| req_wdata_o | output | 8 | Byte to write |
| rsp_valid_i | input | 1 | One pulse per completed request |
| rsp_rdata_i | input | 8 | Byte returned by a read |
| size_mbit_o | output | SIZE_W | Density in Mbit, 0 if unknown |
| rd_lat_o | output | LAT_W | Read latency in cycles |
| burst_bytes_o | output | BURST_W | Burst length in bytes |
| good_die_o | output | 1 | Good-die flag |

## Verification
If the sequencer's state or index goes wrong, it shows up at the request port at the very next handshake. The symptom is a wrong address, a wrong direction or a missing or extra request. The scoreboard compares every accepted request with the expected order, so such a fault is reported on the request where it first appears. A wrong field merge or a capture into the wrong register changes req_wdata_o or the decoded outputs. Both are checked at the write handshake and at done. Device patterns with differing upper bits and differing latency codes make each field distinguishable.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

    localparam int MR_W     = 8;
    localparam int ID_READS = 4;
    localparam int IDX_W    = $clog2(ID_READS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_RD,
        ST_CFG_RD_W,
        ST_CFG_WR,
        ST_CFG_WR_W,
        ST_ID_RD,
        ST_ID_RD_W,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [MR_W-1:0]  wbyte;
        logic [MR_W-1:0]  mr0;
        logic [MR_W-1:0]  mr2;
        logic [MR_W-1:0]  mr8;
    } seq_regs_t;

    // register address visited by each identification step
    function automatic logic [3:0] id_reg_addr(input logic [IDX_W-1:0] step);
        case (step)
            IDX_W'(0): id_reg_addr = 4'h0;
            IDX_W'(1): id_reg_addr = 4'h2;
            IDX_W'(2): id_reg_addr = 4'h4;
            default:   id_reg_addr = 4'h8;
        endcase
    endfunction

endpackage

// File: rtl/psram_mr0_merge.sv
module psram_mr0_merge #(
    parameter logic       LT = 1'b1,
    parameter logic [2:0] RL = 3'd2,
    parameter logic [1:0] DS = 2'd0
) (
    input  logic [7:0] rb_i,
    output logic [7:0] wb_o
);
    // upper two bits keep their read-back value, the rest are replaced
    always_comb begin
        wb_o = {rb_i[7:6], LT, RL, DS};
    end
endmodule

// File: rtl/psram_id_decode.sv
module psram_id_decode #(
    parameter int SIZE_W  = 9,
    parameter int LAT_W   = 5,
    parameter int BURST_W = 11
) (
    input  logic [7:0]         mr0_i,
    input  logic [7:0]         mr2_i,
    input  logic [7:0]         mr8_i,
    output logic [SIZE_W-1:0]  size_mbit_o,
    output logic [LAT_W-1:0]   rd_lat_o,
    output logic [BURST_W-1:0] burst_bytes_o,
    output logic               good_die_o
);
    always_comb begin
        case (mr2_i[2:0])
            3'd1:    size_mbit_o = SIZE_W'(32);
            3'd3:    size_mbit_o = SIZE_W'(64);
            3'd5:    size_mbit_o = SIZE_W'(128);
            3'd7:    size_mbit_o = SIZE_W'(256);
            default: size_mbit_o = '0;
        endcase

        rd_lat_o = LAT_W'({mr0_i[4:2], 1'b0}) + LAT_W'(6);

        case (mr8_i[1:0])
            2'd0:    burst_bytes_o = BURST_W'(16);
            2'd1:    burst_bytes_o = BURST_W'(32);
            2'd2:    burst_bytes_o = BURST_W'(64);
            default: burst_bytes_o = BURST_W'(1024);
        endcase

        good_die_o = mr2_i[7];
    end
endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
    import psram_cfg_pkg::*;
#(
    parameter int         ADDR_W  = 32,
    parameter int         SIZE_W  = 9,
    parameter int         LAT_W   = 5,
    parameter int         BURST_W = 11,
    parameter logic       CFG_LT  = 1'b1,
    parameter logic [2:0] CFG_RL  = 3'd2,
    parameter logic [1:0] CFG_DS  = 2'd0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               done_o,
    output logic               req_valid_o,
    input  logic               req_ready_i,
    output logic               req_write_o,
    output logic [ADDR_W-1:0]  req_addr_o,
    output logic [7:0]         req_wdata_o,
    input  logic               rsp_valid_i,
    input  logic [7:0]         rsp_rdata_i,
    output logic [SIZE_W-1:0]  size_mbit_o,
    output logic [LAT_W-1:0]   rd_lat_o,
    output logic [BURST_W-1:0] burst_bytes_o,
    output logic               good_die_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_READS - 1);

    seq_regs_t  r_d, r_q;
    logic [7:0] merged;

    psram_mr0_merge #(.LT(CFG_LT), .RL(CFG_RL), .DS(CFG_DS)) u_merge (
        .rb_i (rsp_rdata_i),
        .wb_o (merged)
    );

    psram_id_decode #(.SIZE_W(SIZE_W), .LAT_W(LAT_W), .BURST_W(BURST_W)) u_decode (
        .mr0_i         (r_q.mr0),
        .mr2_i         (r_q.mr2),
        .mr8_i         (r_q.mr8),
        .size_mbit_o   (size_mbit_o),
        .rd_lat_o      (rd_lat_o),
        .burst_bytes_o (burst_bytes_o),
        .good_die_o    (good_die_o)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) r_d.st = ST_CFG_RD;
            end
            ST_CFG_RD: begin
                if (req_ready_i) r_d.st = ST_CFG_RD_W;
            end
            ST_CFG_RD_W: begin
                if (rsp_valid_i) begin
                    r_d.wbyte = merged;
                    r_d.st    = ST_CFG_WR;
                end
            end
            ST_CFG_WR: begin
                if (req_ready_i) r_d.st = ST_CFG_WR_W;
            end
            ST_CFG_WR_W: begin
                if (rsp_valid_i) begin
                    r_d.idx = '0;
                    r_d.st  = ST_ID_RD;
                end
            end
            ST_ID_RD: begin
                if (req_ready_i) r_d.st = ST_ID_RD_W;
            end
            ST_ID_RD_W: begin
                if (rsp_valid_i) begin
                    if (r_q.idx == IDX_W'(0)) r_d.mr0 = rsp_rdata_i;
                    if (r_q.idx == IDX_W'(1)) r_d.mr2 = rsp_rdata_i;
                    if (r_q.idx == LAST_IDX)  r_d.mr8 = rsp_rdata_i;
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                        r_d.st  = ST_ID_RD;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        req_valid_o = (r_q.st == ST_CFG_RD) || (r_q.st == ST_CFG_WR) || (r_q.st == ST_ID_RD);
        req_write_o = (r_q.st == ST_CFG_WR);
        req_addr_o  = (r_q.st == ST_ID_RD) ? ADDR_W'(id_reg_addr(r_q.idx)) : '0;
        req_wdata_o = (r_q.st == ST_CFG_WR) ? r_q.wbyte : '0;
        done_o      = (r_q.st == ST_DONE);
    end

endmodule

// File: rtl/psram_cfg_seq_chk.sv
module psram_cfg_seq_chk #(
    parameter int         ADDR_W = 32,
    parameter logic       CFG_LT = 1'b1,
    parameter logic [2:0] CFG_RL = 3'd2,
    parameter logic [1:0] CFG_DS = 2'd0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic              req_valid_o,
    input logic              req_ready_i,
    input logic              req_write_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [7:0]        req_wdata_o,
    input logic              rsp_valid_i
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_write_o))); // R1

    AST_WR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_write_o) |-> (req_wdata_o[5:0] == {CFG_LT, CFG_RL, CFG_DS})); // R2

    AST_WR_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_write_o) |-> (req_addr_o == '0)); // R3

    AST_RD_ADDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_write_o) |-> (req_addr_o == ADDR_W'(0) || req_addr_o == ADDR_W'(2) ||
                                           req_addr_o == ADDR_W'(4) || req_addr_o == ADDR_W'(8))); // R1

    AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(rsp_valid_i)); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !req_valid_o); // R8
endmodule

bind psram_cfg_seq psram_cfg_seq_chk #(
    .ADDR_W (ADDR_W),
    .CFG_LT (CFG_LT),
    .CFG_RL (CFG_RL),
    .CFG_DS (CFG_DS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i)
);

// File: tb/tb_psram_cfg_seq.sv
`timescale 1ns/1ps
module tb_psram_cfg_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        done_o;
    logic        req_valid_o;
    logic        req_ready_i = 1'b0;
    logic        req_write_o;
    logic [31:0] req_addr_o;
    logic [7:0]  req_wdata_o;
    logic        rsp_valid_i = 1'b0;
    logic [7:0]  rsp_rdata_i = 8'h00;
    logic [8:0]  size_mbit_o;
    logic [4:0]  rd_lat_o;
    logic [10:0] burst_bytes_o;
    logic        good_die_o;

    always #2.5 clk = ~clk;

    psram_cfg_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
        .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
        .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i),
        .size_mbit_o(size_mbit_o), .rd_lat_o(rd_lat_o),
        .burst_bytes_o(burst_bytes_o), .good_die_o(good_die_o)
    );

    int total = 0;
    int fails = 0;

    typedef struct { bit wr; logic [31:0] addr; logic [7:0] data; } req_t;
    req_t exp_q[$];

    logic [7:0] devreg [16];
    bit store_writes = 1'b1;
    int rdy_dly = 0;
    int rsp_dly = 0;
    int n_seen  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // driver: expected request stream for a given MR0 power-up value
    task automatic push_expected(input logic [7:0] m0);
        req_t it;
        it = '{wr: 1'b0, addr: 32'h0, data: 8'h00}; exp_q.push_back(it);
        it = '{wr: 1'b1, addr: 32'h0, data: {m0[7:6], 1'b1, 3'd2, 2'd0}}; exp_q.push_back(it);
        it = '{wr: 1'b0, addr: 32'h0, data: 8'h00}; exp_q.push_back(it);
        it = '{wr: 1'b0, addr: 32'h2, data: 8'h00}; exp_q.push_back(it);
        it = '{wr: 1'b0, addr: 32'h4, data: 8'h00}; exp_q.push_back(it);
        it = '{wr: 1'b0, addr: 32'h8, data: 8'h00}; exp_q.push_back(it);
    endtask

    // engine model and monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && req_valid_o) begin
                bit          w;
                logic [31:0] a;
                logic [7:0]  d;
                req_t        e;
                repeat (rdy_dly) @(negedge clk);
                w = req_write_o; a = req_addr_o; d = req_wdata_o;
                req_ready_i = 1'b1;
                @(negedge clk);
                req_ready_i = 1'b0;
                n_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected extra request addr", int'(a), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(w == e.wr, "R1", "request direction", int'(w), int'(e.wr));
                    check(a == e.addr, "R1/R3", "request address", int'(a), int'(e.addr));
                    if (e.wr) check(d == e.data, "R2", "write data", int'(d), int'(e.data));
                end
                if (w && store_writes) devreg[a[3:0]] = d;
                repeat (rsp_dly) @(negedge clk);
                rsp_rdata_i = w ? 8'h00 : devreg[a[3:0]];
                rsp_valid_i = 1'b1;
                @(negedge clk);
                rsp_valid_i = 1'b0;
            end
        end
    end

    function automatic int exp_size(input logic [2:0] c);
        case (c) 3'd1: return 32; 3'd3: return 64; 3'd5: return 128; 3'd7: return 256; default: return 0; endcase
    endfunction

    function automatic int exp_burst(input logic [1:0] c);
        case (c) 2'd0: return 16; 2'd1: return 32; 2'd2: return 64; default: return 1024; endcase
    endfunction

    task automatic run_seq(input logic [7:0] m0, input logic [7:0] m2, input logic [7:0] m8,
                           input bit store, input int rd, input int sd, input bit extra_start);
        logic [7:0] m0_id;
        int         lat;
        int         wait_cnt;
        for (int i = 0; i < 16; i++) devreg[i] = 8'h00;
        devreg[0] = m0; devreg[2] = m2; devreg[4] = 8'hA5; devreg[8] = m8;
        store_writes = store; rdy_dly = rd; rsp_dly = sd; n_seen = 0;
        m0_id = store ? {m0[7:6], 1'b1, 3'd2, 2'd0} : m0;
        lat   = int'(m0_id[4:2]) * 2 + 6;
        push_expected(m0);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        check(done_o == 1'b0, "R8", "done low after start", int'(done_o), 0);
        if (extra_start) begin
            repeat (4) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        wait_cnt = 0;
        while (!done_o && wait_cnt < 2000) begin @(negedge clk); wait_cnt++; end
        check(done_o == 1'b1, "R8", "done reached", int'(done_o), 1);
        check(n_seen == 6, "R8/R9", "requests before done", n_seen, 6);
        check(int'(size_mbit_o) == exp_size(m2[2:0]), "R4", "size", int'(size_mbit_o), exp_size(m2[2:0]));
        check(good_die_o == m2[7], "R5", "good die", int'(good_die_o), int'(m2[7]));
        check(int'(rd_lat_o) == lat, "R6", "read latency", int'(rd_lat_o), lat);
        check(int'(burst_bytes_o) == exp_burst(m8[1:0]), "R7", "burst", int'(burst_bytes_o), exp_burst(m8[1:0]));
        repeat (6) @(negedge clk);
        check(done_o == 1'b1 && req_valid_o == 1'b0, "R8", "done held, no request",
              int'({done_o, req_valid_o}), 2);
        check(exp_q.size() == 0, "R9", "pending expected requests", exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R11", "reset done", int'(done_o), 0);
        check(req_valid_o == 1'b0, "R11", "reset req_valid", int'(req_valid_o), 0);
        check(size_mbit_o == 9'd0, "R11", "reset size", int'(size_mbit_o), 0);
        check(rd_lat_o == 5'd6, "R11", "reset latency", int'(rd_lat_o), 6);
        check(burst_bytes_o == 11'd16, "R11", "reset burst", int'(burst_bytes_o), 16);
        check(good_die_o == 1'b0, "R11", "reset good die", int'(good_die_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_seq(8'hC0, 8'h83, 8'h01, 1'b1, 0, 0, 1'b0);
        run_seq(8'h1F, 8'h07, 8'h03, 1'b0, 2, 3, 1'b1);
        run_seq(8'h00, 8'h85, 8'h02, 1'b0, 1, 0, 1'b0);
        run_seq(8'h6C, 8'h02, 8'h04, 1'b1, 0, 2, 1'b1);
        run_seq(8'h9B, 8'h81, 8'h00, 1'b0, 3, 1, 1'b0);

        // R10: stray response while done must not change anything
        begin
            logic [8:0]  s0; logic [4:0] l0; logic [10:0] b0; logic g0;
            s0 = size_mbit_o; l0 = rd_lat_o; b0 = burst_bytes_o; g0 = good_die_o;
            rsp_rdata_i = 8'hFF; rsp_valid_i = 1'b1;
            @(negedge clk); rsp_valid_i = 1'b0;
            repeat (2) @(negedge clk);
            check(size_mbit_o == s0 && rd_lat_o == l0 && burst_bytes_o == b0 && good_die_o == g0,
                  "R10", "outputs after stray response",
                  int'({size_mbit_o, rd_lat_o, burst_bytes_o, good_die_o}), int'({s0, l0, b0, g0}));
            check(done_o == 1'b1 && req_valid_o == 1'b0, "R10", "state after stray response",
                  int'({done_o, req_valid_o}), 2);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule